// File: doc/BRIEF.md
# BCD Real-Time Calendar Core

This block keeps wall-clock time and date from a slow reference clock. The first prescaler stage divides the reference clock, and the second stage divides its output again to produce one tick per second. Each tick advances a time-of-day and a calendar date. Both are held in packed binary-coded-decimal words that software reads directly. The second stage's running count is also available as a binary sub-second value.

New values can be loaded only while an external protection block holds the core in its initialisation state. The loadable values are the two divisor values, the 12/24-hour format bit, and the time and date words. In that state, the calendar does not advance and both prescaler stages rest at their programmed start values. When the state is left, counting resumes with a full second. The hour counter runs either 00–23 or in the 12-hour form with a PM flag. The date logic tracks month lengths, a four-year leap rule, year rollover 99→00 and a weekday that cycles 1..7.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the core reads time 00:00:00 with PM clear, 24-hour format, and date year 00, month 01, day 01, weekday 1. Its divisors are 127 and 255, so subsec reads 255 while initialisation is held.
- R2: One second elapses every (A+1)·(S+1) clock cycles, where A and S are the two programmed divisor values. At reset these give 32768 cycles per second.
- R3: subsec is a binary count that starts at S, decrements once per first-stage tick, and reloads to S on the tick that advances the seconds.
- R4: time_word packs seconds units [3:0] and tens [6:4], minutes units [11:8] and tens [14:12], hour units [19:16] and tens [21:20], and PM [22]. Seconds and minutes wrap 59→00 and carry into the next field.
- R5: In 24-hour format (format bit 0), hours wrap 23→00 and advance the date.
- R6: In 12-hour format (format bit 1), hours step 12→01 and 11→12. The PM flag toggles on the 11→12 step, and the date advances only when 11 PM steps to 12 AM.
- R7: date_word packs day units [3:0] and tens [5:4], month units [11:8] and tens [12], weekday [15:13], and year units [19:16] and tens [23:20]. Days 30 and 31 end the month according to month length.
- R8: February ends after day 29 when the year is divisible by 4, and after day 28 otherwise.
- R9: Month wraps 12→01 and increments the year; year wraps 99→00.
- R10: The weekday advances with the day and wraps 7→1.
- R11: While init_mode is high the calendar and prescalers are held and loads take effect. Loads attempted while init_mode is low change nothing.
- R12: When init_mode falls, any partial second is discarded and the next second completes a full (A+1)·(S+1) cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| init_mode | input | 1 | Initialisation hold from the protection block |
| cfg_load | input | 1 | Load divisors and format (init only) |
| cfg_fmt12 | input | 1 | Format: 0 = 24-hour, 1 = 12-hour |
| cfg_pre_a | input | APRE_W (7) | First-stage divisor value A |
| cfg_pre_s | input | SPRE_W (15) | Second-stage divisor value S |
| wr_time | input | 1 | Load time_word from wr_data (init only) |
| wr_date | input | 1 | Load date_word from wr_data (init only) |
| wr_data | input | 32 | Packed value to load |
| time_word | output | 32 | Packed BCD time of day |
| date_word | output | 32 | Packed BCD date |
| subsec | output | SPRE_W (15) | Binary sub-second count |

## Verification
The main function is tried by loading a starting time and date, running a set number of seconds with small divisors, and comparing both words.

The starting points are chosen to separate the carry paths:
- a plain unit step;
- second and minute carries;
- midnight;
- the end of 30-day and 31-day months, including the 09→10 month step;
- February in leap and non-leap years;
- year-end with and without the 99 wrap;
- the three distinct 12-hour transitions.

Directed runs cover the remaining behaviour. A run with the reset divisors confirms the exact 32768-cycle period. A cycle-by-cycle trace of subsec covers the sub-second count. Writes attempted outside initialisation are shown to be ignored, and an interrupted partial second is shown to be discarded.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef struct packed {
    logic       pm;
    logic [7:0] hr;
    logic [7:0] mn;
    logic [7:0] sc;
  } tod_t;

  typedef struct packed {
    logic [7:0] yr;
    logic [2:0] wd;
    logic [7:0] mo;
    logic [7:0] dy;
  } cdate_t;

  // Increment a two-digit BCD value with decimal carry between digits.
  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Year divisible by 4, judged on the BCD digits.
  function automatic logic bcd_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] hour12_step(input logic [7:0] h);
    if (h == 8'h12) return 8'h01;
    return bcd_step(h);
  endfunction

  function automatic logic [31:0] pack_tod(input tod_t t);
    return {9'd0, t.pm, t.hr[5:0], 1'b0, t.mn[6:0], 1'b0, t.sc[6:0]};
  endfunction

  function automatic tod_t unpack_tod(input logic [31:0] w);
    tod_t t;
    t.pm = w[22];
    t.hr = {2'b00, w[21:16]};
    t.mn = {1'b0, w[14:8]};
    t.sc = {1'b0, w[6:0]};
    return t;
  endfunction

  function automatic logic [31:0] pack_date(input cdate_t d);
    return {8'd0, d.yr, d.wd, d.mo[4:0], 2'b00, d.dy[5:0]};
  endfunction

  function automatic cdate_t unpack_date(input logic [31:0] w);
    cdate_t d;
    d.yr = w[23:16];
    d.wd = w[15:13];
    d.mo = {3'b000, w[12:8]};
    d.dy = {2'b00, w[5:0]};
    return d;
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int AW     = 7,
  parameter int SW     = 15,
  parameter int A_INIT = 127,
  parameter int S_INIT = 255
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic [AW-1:0] div_a,
  input  logic [SW-1:0] div_s,
  output logic [SW-1:0] sub_cnt,
  output logic          apre_tick,
  output logic          sec_tick
);
  logic [AW-1:0] a_cnt;
  logic [SW-1:0] s_cnt;

  assign apre_tick = !hold && (a_cnt == '0);
  assign sec_tick  = apre_tick && (s_cnt == '0);
  assign sub_cnt   = s_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_cnt <= AW'(A_INIT);
      s_cnt <= SW'(S_INIT);
    end else if (hold) begin
      a_cnt <= div_a;
      s_cnt <= div_s;
    end else if (a_cnt == '0) begin
      a_cnt <= div_a;
      s_cnt <= (s_cnt == '0) ? div_s : s_cnt - SW'(1);
    end else begin
      a_cnt <= a_cnt - AW'(1);
    end
  end
endmodule

// File: rtl/cal_time.sv
module cal_time
  import cal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic fmt12,
  input  logic ld,
  input  tod_t ld_val,
  output tod_t q,
  output logic day_carry
);
  logic sec_wrap, min_wrap, hr_last;
  tod_t nxt;

  assign sec_wrap  = (q.sc == 8'h59);
  assign min_wrap  = sec_wrap && (q.mn == 8'h59);
  assign hr_last   = fmt12 ? ((q.hr == 8'h11) && q.pm) : (q.hr == 8'h23);
  assign day_carry = step && min_wrap && hr_last;

  always_comb begin
    nxt = q;
    nxt.sc = sec_wrap ? 8'h00 : bcd_step(q.sc);
    if (sec_wrap) nxt.mn = (q.mn == 8'h59) ? 8'h00 : bcd_step(q.mn);
    if (min_wrap) begin
      if (fmt12) begin
        nxt.hr = hour12_step(q.hr);
        if (q.hr == 8'h11) nxt.pm = !q.pm;
      end else begin
        nxt.hr = (q.hr == 8'h23) ? 8'h00 : bcd_step(q.hr);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (ld)   q <= ld_val;
    else if (step) q <= nxt;
  end
endmodule

// File: rtl/cal_date.sv
module cal_date
  import cal_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   step,
  input  logic   ld,
  input  cdate_t ld_val,
  output cdate_t q
);
  logic   end_of_month, end_of_year;
  cdate_t nxt;

  assign end_of_month = (q.dy == month_last_day(q.mo, q.yr));
  assign end_of_year  = end_of_month && (q.mo == 8'h12);

  always_comb begin
    nxt    = q;
    nxt.wd = (q.wd == 3'd7) ? 3'd1 : q.wd + 3'd1;
    nxt.dy = end_of_month ? 8'h01 : bcd_step(q.dy);
    if (end_of_month) nxt.mo = (q.mo == 8'h12) ? 8'h01 : bcd_step(q.mo);
    if (end_of_year)  nxt.yr = (q.yr == 8'h99) ? 8'h00 : bcd_step(q.yr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '{yr: 8'h00, wd: 3'd1, mo: 8'h01, dy: 8'h01};
    else if (ld)   q <= ld_val;
    else if (step) q <= nxt;
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int APRE_W   = 7,
  parameter int SPRE_W   = 15,
  parameter int APRE_RST = 127,
  parameter int SPRE_RST = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_mode,
  input  logic              cfg_load,
  input  logic              cfg_fmt12,
  input  logic [APRE_W-1:0] cfg_pre_a,
  input  logic [SPRE_W-1:0] cfg_pre_s,
  input  logic              wr_time,
  input  logic              wr_date,
  input  logic [31:0]       wr_data,
  output logic [31:0]       time_word,
  output logic [31:0]       date_word,
  output logic [SPRE_W-1:0] subsec
);
  logic [APRE_W-1:0] div_a;
  logic [SPRE_W-1:0] div_s;
  logic              fmt12;
  logic              apre_tick, sec_tick, day_tick;
  logic              ld_time, ld_date, ld_cfg;
  tod_t              tod_q;
  cdate_t            date_q;

  assign ld_cfg  = init_mode && cfg_load;
  assign ld_time = init_mode && wr_time;
  assign ld_date = init_mode && wr_date;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_a <= APRE_W'(APRE_RST);
      div_s <= SPRE_W'(SPRE_RST);
      fmt12 <= 1'b0;
    end else if (ld_cfg) begin
      div_a <= cfg_pre_a;
      div_s <= cfg_pre_s;
      fmt12 <= cfg_fmt12;
    end
  end

  cal_prescaler #(.AW(APRE_W), .SW(SPRE_W), .A_INIT(APRE_RST), .S_INIT(SPRE_RST)) u_pre (
    .clk(clk), .rst_n(rst_n), .hold(init_mode), .div_a(div_a), .div_s(div_s),
    .sub_cnt(subsec), .apre_tick(apre_tick), .sec_tick(sec_tick)
  );

  cal_time u_time (
    .clk(clk), .rst_n(rst_n), .step(sec_tick), .fmt12(fmt12), .ld(ld_time),
    .ld_val(unpack_tod(wr_data)), .q(tod_q), .day_carry(day_tick)
  );

  cal_date u_date (
    .clk(clk), .rst_n(rst_n), .step(day_tick), .ld(ld_date),
    .ld_val(unpack_date(wr_data)), .q(date_q)
  );

  assign time_word = pack_tod(tod_q);
  assign date_word = pack_date(date_q);
endmodule

// File: rtl/cal_chk.sv
module cal_chk #(
  parameter int SW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          init_mode,
  input logic          wr_time,
  input logic          wr_date,
  input logic          sec_tick,
  input logic          day_tick,
  input logic [SW-1:0] subsec,
  input logic [31:0]   time_word,
  input logic [31:0]   date_word
);
  // R11
  init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_mode |-> !sec_tick);

  // R2
  tick_moves_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> time_word != $past(time_word));

  // R4
  time_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !(init_mode && wr_time)) |=> $stable(time_word));

  // R7
  date_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!day_tick && !(init_mode && wr_date)) |=> $stable(date_word));

  // R5
  day_needs_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    day_tick |-> sec_tick);

  // R3
  sub_zero_at_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> subsec == '0);
endmodule

bind bcd_calendar cal_chk #(.SW(SPRE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .init_mode(init_mode), .wr_time(wr_time),
  .wr_date(wr_date), .sec_tick(sec_tick), .day_tick(day_tick),
  .subsec(subsec), .time_word(time_word), .date_word(date_word)
);

// File: tb/sim_bcd_calendar.sv
module sim_bcd_calendar;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_mode = 1'b1;
  logic        cfg_load = 1'b0;
  logic        cfg_fmt12 = 1'b0;
  logic [6:0]  cfg_pre_a = '0;
  logic [14:0] cfg_pre_s = '0;
  logic        wr_time = 1'b0;
  logic        wr_date = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] time_word, date_word;
  logic [14:0] subsec;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bcd_calendar u0 (
    .clk(clk), .rst_n(rst_n), .init_mode(init_mode), .cfg_load(cfg_load),
    .cfg_fmt12(cfg_fmt12), .cfg_pre_a(cfg_pre_a), .cfg_pre_s(cfg_pre_s),
    .wr_time(wr_time), .wr_date(wr_date), .wr_data(wr_data),
    .time_word(time_word), .date_word(date_word), .subsec(subsec)
  );

  // fmt, seconds to run, start time, start date, expected time, expected date
  typedef struct packed {
    logic        fmt;
    logic [7:0]  nsec;
    logic [31:0] t0;
    logic [31:0] d0;
    logic [31:0] te;
    logic [31:0] de;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd1, 32'h00123456, 32'h00246517, 32'h00123457, 32'h00246517}, // R2 plain step
    '{1'b0, 8'd1, 32'h00000059, 32'h00246517, 32'h00000100, 32'h00246517}, // R4 sec carry
    '{1'b0, 8'd1, 32'h00105959, 32'h00246517, 32'h00110000, 32'h00246517}, // R4 min carry
    '{1'b0, 8'd1, 32'h00235959, 32'h00246517, 32'h00000000, 32'h00248518}, // R5 midnight
    '{1'b0, 8'd1, 32'h00235959, 32'h0023E430, 32'h00000000, 32'h00232501}, // R7 R10 30-day month, wd 7->1
    '{1'b0, 8'd1, 32'h00235959, 32'h00244131, 32'h00000000, 32'h00246201}, // R7 31-day month
    '{1'b0, 8'd1, 32'h00235959, 32'h00244228, 32'h00000000, 32'h00246229}, // R8 leap 28->29
    '{1'b0, 8'd1, 32'h00235959, 32'h00244229, 32'h00000000, 32'h00246301}, // R8 leap 29->01
    '{1'b0, 8'd1, 32'h00235959, 32'h00234228, 32'h00000000, 32'h00236301}, // R8 non-leap
    '{1'b0, 8'd1, 32'h00235959, 32'h0099F231, 32'h00000000, 32'h00002101}, // R9 year 99->00
    '{1'b0, 8'd1, 32'h00235959, 32'h00193231, 32'h00000000, 32'h00204101}, // R9 year 19->20
    '{1'b0, 8'd1, 32'h00235959, 32'h0023A930, 32'h00000000, 32'h0023D001}, // R7 month 09->10
    '{1'b0, 8'd1, 32'h00235959, 32'h0023B030, 32'h00000000, 32'h0023D031}, // R7 Oct 30->31
    '{1'b0, 8'd1, 32'h00235959, 32'h0023B130, 32'h00000000, 32'h0023D201}, // R7 Nov end
    '{1'b1, 8'd1, 32'h00115959, 32'h00246517, 32'h00520000, 32'h00246517}, // R6 11AM->12PM
    '{1'b1, 8'd1, 32'h00525959, 32'h00246517, 32'h00410000, 32'h00246517}, // R6 12PM->1PM
    '{1'b1, 8'd1, 32'h00515959, 32'h00246517, 32'h00120000, 32'h00248518}, // R6 11PM->12AM
    '{1'b0, 8'd3, 32'h00000000, 32'h00246517, 32'h00000003, 32'h00246517}, // R2 three seconds
    '{1'b1, 8'd2, 32'h00125958, 32'h00246517, 32'h00010000, 32'h00246517}  // R6 12AM->1AM
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Enter init, program A=1 S=2 (6 cycles per second), load time and date.
  task automatic setup(input logic fmt, input logic [31:0] t, input logic [31:0] d);
    @(negedge clk);
    init_mode = 1'b1;
    cfg_load = 1'b1; cfg_fmt12 = fmt; cfg_pre_a = 7'd1; cfg_pre_s = 15'd2;
    wr_time = 1'b1; wr_data = t;
    @(negedge clk);
    cfg_load = 1'b0; wr_time = 1'b0; wr_date = 1'b1; wr_data = d;
    @(negedge clk);
    wr_date = 1'b0;
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 time", time_word, 32'h00000000);
    check("R1 date", date_word, 32'h00002101);
    check("R1 subsec", {17'd0, subsec}, 32'd255);

    // R2 reset divisors: 32768 cycles per second
    init_mode = 1'b0;
    tick(32767);
    check("R2 default period early", time_word, 32'h00000000);
    tick(1);
    check("R2 default period", time_word, 32'h00000001);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      setup(VECS[i].fmt, VECS[i].t0, VECS[i].d0);
      init_mode = 1'b0;
      tick(6 * int'(VECS[i].nsec));
      check($sformatf("vector %0d time (R2-R10)", i), time_word, VECS[i].te);
      check($sformatf("vector %0d date (R2-R10)", i), date_word, VECS[i].de);
    end

    // R3 subsec trace with A=1 S=2
    setup(1'b0, 32'h00000000, 32'h00002101);
    check("R3 subsec held", {17'd0, subsec}, 32'd2);
    init_mode = 1'b0;
    tick(2);
    check("R3 subsec after first stage tick", {17'd0, subsec}, 32'd1);
    tick(2);
    check("R3 subsec at zero", {17'd0, subsec}, 32'd0);
    tick(2);
    check("R3 subsec reload", {17'd0, subsec}, 32'd2);

    // R11 hold during init, writes outside init ignored
    setup(1'b0, 32'h00000000, 32'h00002101);
    tick(20);
    check("R11 held in init", time_word, 32'h00000000);
    init_mode = 1'b0;
    tick(1);
    wr_time = 1'b1; wr_date = 1'b1; wr_data = 32'h00123456;
    cfg_load = 1'b1; cfg_pre_a = 7'd0; cfg_pre_s = 15'd0; cfg_fmt12 = 1'b1;
    tick(1);
    wr_time = 1'b0; wr_date = 1'b0; cfg_load = 1'b0;
    tick(4);
    check("R11 time write ignored", time_word, 32'h00000001);
    check("R11 date write ignored", date_word, 32'h00002101);
    tick(5);
    check("R11 divisor write ignored", time_word, 32'h00000001);
    tick(1);
    check("R11 period unchanged", time_word, 32'h00000002);

    // R12 partial second discarded on init exit
    setup(1'b0, 32'h00000000, 32'h00002101);
    init_mode = 1'b0;
    tick(4);
    init_mode = 1'b1;
    tick(3);
    init_mode = 1'b0;
    tick(5);
    check("R12 restart early", time_word, 32'h00000000);
    tick(1);
    check("R12 restart full period", time_word, 32'h00000001);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule